// File: doc/BRIEF.md
# Aliased 8/16-bit Register File

This block is the general-purpose register store of a small 8-bit core. Sixteen byte-wide registers sit behind two combinational read ports, which supply ALU operands, and one synchronous write port, which takes results back. Register zero is a constant zero: a read of it returns 0 and a write to it is dropped.

A third read port returns 16 bits and has its own index. Indices 0 to 9 give the matching byte register zero-extended. Indices 10 to 15 give a pair of byte registers joined as high byte then low byte, and the core uses these as base addresses for loads, stores and far jumps. The pairs are: 10 gives r4:r5, 11 gives r6:r7, 12 gives r8:r9, 13 gives r10:r11, 14 gives r12:r13, 15 gives r14:r15. A one-bit carry flag is held next to the registers and has its own write enable.

Top module: `regfile_alias`

## Requirements
- R1: After reset every byte register reads 0 on all ports and the carry output is 0.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored in register `wr_idx`. The new value shows on the read ports from the cycle after that edge.
- R3: A write to index 0 is ignored. Index 0 reads 0 on both byte ports and on the wide port.
- R4: Both byte read ports are combinational and independent. Each returns the current content of the register its own index selects.
- R5: When `xrd_idx` is 0 to 9, `xrd_data` is {8'h00, register[xrd_idx]}.
- R6: When `xrd_idx` is k with 10 ≤ k ≤ 15, `xrd_data` is {register[2k-16], register[2k-15]}. The high byte is the even-numbered register.
- R7: When `cy_we` is high at a rising edge, the carry takes `cy_in` from the next cycle on. When `cy_we` is low, the carry holds its value and `cy_in` has no effect.
- R8: A write with `wr_en` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Index for byte read port A |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_idx | input | 4 | Index for byte read port B |
| rd_b_data | output | 8 | Byte read port B data |
| xrd_idx | input | 4 | Index for the wide read port |
| xrd_data | output | 16 | Wide read data, zero-extended or paired |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 8 | Write data |
| cy_we | input | 1 | Carry write enable |
| cy_in | input | 1 | Next carry value |
| cy_out | output | 1 | Current carry |

## Verification
The first pass writes a distinct byte to every register, so that every wide pair shows a different high byte and low byte. A swapped byte order or a wrong pair offset then shows up as a mismatch. Later passes use random writes and random read indices, including index 0 and reads of the same index being written, and they turn the enables on and off. These passes separate a correct one-cycle write latency from a bypassed or lost write. They also catch a carry that moves while its enable is low.

// File: rtl/regfile_alias.sv
module regfile_alias #(
  parameter int DW = 8,
  parameter int NREG = 16,
  parameter int PAIR_BASE = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            rd_a_idx,
  output logic [DW-1:0]         rd_a_data,
  input  logic [3:0]            rd_b_idx,
  output logic [DW-1:0]         rd_b_data,
  input  logic [3:0]            xrd_idx,
  output logic [2*DW-1:0]       xrd_data,
  input  logic                  wr_en,
  input  logic [3:0]            wr_idx,
  input  logic [DW-1:0]         wr_data,
  input  logic                  cy_we,
  input  logic                  cy_in,
  output logic                  cy_out
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];
  logic          cy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && wr_idx != '0) begin
      regs[wr_idx[IW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cy_q <= 1'b0;
    else if (cy_we) cy_q <= cy_in;
  end

  assign rd_a_data = (rd_a_idx == '0) ? '0 : regs[rd_a_idx[IW-1:0]];
  assign rd_b_data = (rd_b_idx == '0) ? '0 : regs[rd_b_idx[IW-1:0]];
  assign cy_out    = cy_q;

  logic [IW-1:0] hi_idx, lo_idx;
  assign hi_idx = IW'({xrd_idx, 1'b0} - 5'd16);
  assign lo_idx = IW'({xrd_idx, 1'b1} - 5'd16);

  always_comb begin
    if (xrd_idx < 4'(PAIR_BASE))
      xrd_data = {{DW{1'b0}}, (xrd_idx == '0) ? {DW{1'b0}} : regs[xrd_idx[IW-1:0]]};
    else
      xrd_data = {regs[hi_idx], regs[lo_idx]};
  end
endmodule

// File: rtl/regfile_alias_chk.sv
module regfile_alias_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [7:0]  rd_a_data,
  input logic [3:0]  rd_b_idx,
  input logic [7:0]  rd_b_data,
  input logic [3:0]  xrd_idx,
  input logic [15:0] xrd_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [7:0]  wr_data,
  input logic        cy_we,
  input logic        cy_in,
  input logic        cy_out
);
  a_r3_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 4'd0 |-> rd_a_data == 8'd0);
  a_r3_zero_x: assert property (@(posedge clk) disable iff (!rst_n)
    xrd_idx == 4'd0 |-> xrd_data == 16'd0);
  a_r5_zext: assert property (@(posedge clk) disable iff (!rst_n)
    xrd_idx < 4'd10 |-> xrd_data[15:8] == 8'd0);
  a_r4_same_idx: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == rd_b_idx |-> rd_a_data == rd_b_data);
  a_r6_pair_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (xrd_idx >= 4'd10 && rd_a_idx == {xrd_idx[2:0], 1'b1}) |-> xrd_data[7:0] == rd_a_data);
  a_r6_pair_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (xrd_idx >= 4'd10 && rd_b_idx == {xrd_idx[2:0], 1'b0}) |-> xrd_data[15:8] == rd_b_data);
  a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'd0 && rd_a_idx == wr_idx) ##1 (rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cy_we |=> $stable(cy_out));
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    cy_we |=> cy_out == $past(cy_in));
endmodule

bind regfile_alias regfile_alias_chk u_chk (.*);

// File: tb/tb_regfile_alias.sv
`timescale 1ns/1ps
module tb_regfile_alias;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, xrd_idx = 0, wr_idx = 0;
  logic [7:0] rd_a_data, rd_b_data, wr_data = 0;
  logic [15:0] xrd_data;
  logic wr_en = 0, cy_we = 0, cy_in = 0, cy_out;

  always #4 clk = ~clk;

  regfile_alias dut (.*);

  int unsigned model [16];
  int unsigned mcy;
  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic int unsigned mx(input int unsigned k);
    if (k < 10) return model[k];
    return (model[2*k-16] << 8) | model[2*k-15];
  endfunction

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, "/R4 port A"}, rd_a_data, model[rd_a_idx]);
    chk({req, "/R4 port B"}, rd_b_data, model[rd_b_idx]);
    chk({req, xrd_idx < 10 ? "/R5 wide" : "/R6 wide"}, xrd_data, mx(xrd_idx));
    chk({req, "/R7 carry"}, cy_out, mcy);
  endtask

  task automatic cyc(input bit we, input int wi, input int wd, input bit cw, input bit ci,
                     input int ra, input int rb, input int rx, input string req);
    wr_en = we; wr_idx = 4'(wi); wr_data = 8'(wd); cy_we = cw; cy_in = ci;
    rd_a_idx = 4'(ra); rd_b_idx = 4'(rb); xrd_idx = 4'(rx);
    #1 compare_all(req);
    @(posedge clk);
    if (we && wi != 0) model[wi] = wd & 8'hff;
    if (cw) mcy = ci;
    #2 compare_all(req);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    mcy = 0;
    #20 rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 0, i, 15 - i, i, "R1 reset");
    for (int i = 0; i < 16; i++) cyc(1, i, 8'h11 * i + 8'h3, 0, 0, i, i, i, "R2 fill");
    for (int k = 0; k < 16; k++) cyc(0, 0, 0, 0, 0, 2*k % 16, (2*k+1) % 16, k, "R6 pairs");
    cyc(1, 0, 8'hAA, 0, 0, 0, 0, 0, "R3 zero write");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R3 zero read");
    cyc(0, 5, 8'h77, 0, 0, 5, 5, 10, "R8 disabled write");
    cyc(0, 0, 0, 1, 1, 1, 2, 3, "R7 set");
    cyc(0, 0, 0, 0, 0, 1, 2, 3, "R7 hold");
    cyc(0, 0, 0, 0, 0, 1, 2, 3, "R7 hold");
    cyc(0, 0, 0, 1, 0, 1, 2, 3, "R7 clear");
    for (int n = 0; n < 3000; n++)
      cyc($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 255),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 15),
          $urandom_range(0, 15), $urandom_range(0, 15), "R2 random");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule